// File: doc/BRIEF.md
# Operand-Isolated Adder Datapath

This block is a two-stage datapath. An adder feeds two destination registers through a chain of multiplexers. Each register has its own load enable. Every multiplexer also has an alternative data source. The block adds operand isolation around the adder. An activation signal is worked out from the incoming selects and load enables. When no destination will take the sum, the activation signal is low and the enabled flops that hold the adder operands keep their previous contents, so changes on A and B do not reach the adder.

Stage one registers the controls, the alternative sources and, when active, the operands. Stage two adds the held operands and loads the destination registers. A vector presented before clock edge k therefore appears in the registers after edge k+1. The register contents match, cycle for cycle, the same datapath with the isolation removed. A wrapping counter of operand bit changes is brought out so that the reduced input toggling can be observed.

The control path has two named conditions. The block is "active" when at least one destination takes the sum. It is "idle" otherwise. A vector moves the block from one condition to the other only through its own selects and enables.

Top module: `iso_adder_dp`

## Requirements
- R1: While `rst_n` is low, `r0_q`, `r1_q` and `toggle_cnt` are zero, and the held operands are zero.
- R2: With `r0_ld`=1 and `r0_pick`=0, `r0_q` takes (A + B) mod 2^W two rising edges after the vector is applied.
- R3: With `r0_ld`=1 and `r0_pick`=1, `r0_q` takes `alt0` with the same two-edge latency.
- R4: With `r1_ld`=1, `r1_q` takes `alt2` when `r1_pick_hi`=1, `alt1` when `r1_pick_hi`=0 and `r1_pick_lo`=1, and the sum when both are 0.
- R5: A register whose load enable is 0 keeps its value.
- R6: The block is active exactly when (`r0_ld` AND `r0_pick`=0) OR (`r1_ld` AND `r1_pick_lo`=0 AND `r1_pick_hi`=0). When it is idle, `toggle_cnt` does not change, whatever A and B do.
- R7: When the block is active, `toggle_cnt` grows, one edge later, by the number of bits that differ between the new A and B and the last captured A and B. It wraps modulo 2^CNT_W.
- R8: Both registers can take the same sum in the same cycle.
- R9: After any run of idle cycles, the next sum stored is built from the operands of the vector that makes the block active. It is never built from stale operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | W | Adder operand A |
| opb | input | W | Adder operand B |
| r0_pick | input | 1 | r0 source: 0 sum, 1 alt0 |
| r1_pick_lo | input | 1 | r1 inner mux: 0 sum, 1 alt1 |
| r1_pick_hi | input | 1 | r1 outer mux: 0 inner result, 1 alt2 |
| r0_ld | input | 1 | r0 load enable |
| r1_ld | input | 1 | r1 load enable |
| alt0 | input | W | Alternative source for r0 |
| alt1 | input | W | Inner alternative source for r1 |
| alt2 | input | W | Outer alternative source for r1 |
| r0_q | output | W | Destination register 0 |
| r1_q | output | W | Destination register 1 |
| toggle_cnt | output | CNT_W | Count of operand bit changes at the adder |

## Verification
On every cycle, the assertions check that the held operands and the toggle counter stay frozen while the block is idle. They also check that a disabled register holds its value and that the alternative sources reach their registers with the right priority. Only the bench scenarios can show the sums themselves and the exact Hamming increments of the counter. The bench scenarios are also what shows equivalence with an unisolated datapath across idle gaps, where the operands change while nobody consumes the sum.

// File: rtl/iso_pkg.sv
package iso_pkg;

    typedef struct packed {
        logic load1;
        logic load0;
        logic pick_hi;
        logic pick_lo;
        logic pick0;
    } iso_ctrl_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } iso_mode_t;

endpackage

// File: rtl/iso_activation.sv
module iso_activation
    import iso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  iso_ctrl_t ctrl_i,
    input  logic [W-1:0] alt0_i,
    input  logic [W-1:0] alt1_i,
    input  logic [W-1:0] alt2_i,
    output logic      act_o,
    output iso_ctrl_t ctrl_q,
    output logic [W-1:0] alt0_q,
    output logic [W-1:0] alt1_q,
    output logic [W-1:0] alt2_q
);

    iso_mode_t mode_next;

    always_comb begin
        mode_next = ST_IDLE;
        if ((ctrl_i.load0 && !ctrl_i.pick0) ||
            (ctrl_i.load1 && !ctrl_i.pick_lo && !ctrl_i.pick_hi))
            mode_next = ST_ACTIVE;
    end

    always_comb begin
        unique case (mode_next)
            ST_ACTIVE: act_o = 1'b1;
            ST_IDLE:   act_o = 1'b0;
            default:   act_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            alt0_q <= '0;
            alt1_q <= '0;
            alt2_q <= '0;
        end else begin
            ctrl_q <= ctrl_i;
            alt0_q <= alt0_i;
            alt1_q <= alt1_i;
            alt2_q <= alt2_i;
        end
    end

endmodule

// File: rtl/iso_hold.sv
module iso_hold #(
    parameter int W     = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic [W-1:0]     a_q,
    output logic [W-1:0]     b_q,
    output logic [CNT_W-1:0] tog_o
);

    localparam int HW = $clog2(2*W+1);

    function automatic logic [HW-1:0] ones(input logic [W-1:0] v);
        logic [HW-1:0] n;
        n = '0;
        for (int i = 0; i < W; i++) n = n + HW'(v[i]);
        return n;
    endfunction

    logic [CNT_W-1:0] delta;

    always_comb begin
        delta = CNT_W'(ones(a_i ^ a_q)) + CNT_W'(ones(b_i ^ b_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            tog_o <= '0;
        end else if (act_i) begin
            a_q   <= a_i;
            b_q   <= b_i;
            tog_o <= tog_o + delta;
        end
    end

    a_r6_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> ($stable(a_q) && $stable(b_q)));

    a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> $stable(tog_o));

endmodule

// File: rtl/iso_dest.sv
module iso_dest
    import iso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  iso_ctrl_t    ctrl_q,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] alt0_q,
    input  logic [W-1:0] alt1_q,
    input  logic [W-1:0] alt2_q,
    output logic [W-1:0] r0_o,
    output logic [W-1:0] r1_o
);

    logic [W-1:0] r0_src, r1_inner, r1_src;

    always_comb begin
        r0_src   = ctrl_q.pick0   ? alt0_q : sum_i;
        r1_inner = ctrl_q.pick_lo ? alt1_q : sum_i;
        r1_src   = ctrl_q.pick_hi ? alt2_q : r1_inner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r0_o <= '0;
            r1_o <= '0;
        end else begin
            if (ctrl_q.load0) r0_o <= r0_src;
            if (ctrl_q.load1) r1_o <= r1_src;
        end
    end

    a_r5_r0_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.load0 |=> $stable(r0_o));

    a_r5_r1_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.load1 |=> $stable(r1_o));

    a_r3_alt0_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.load0 && ctrl_q.pick0) |=> (r0_o == $past(alt0_q)));

    a_r4_alt2_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.load1 && ctrl_q.pick_hi) |=> (r1_o == $past(alt2_q)));

endmodule

// File: rtl/iso_adder_dp.sv
module iso_adder_dp
    import iso_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             r0_pick,
    input  logic             r1_pick_lo,
    input  logic             r1_pick_hi,
    input  logic             r0_ld,
    input  logic             r1_ld,
    input  logic [W-1:0]     alt0,
    input  logic [W-1:0]     alt1,
    input  logic [W-1:0]     alt2,
    output logic [W-1:0]     r0_q,
    output logic [W-1:0]     r1_q,
    output logic [CNT_W-1:0] toggle_cnt
);

    iso_ctrl_t    ctrl_in, ctrl_q;
    logic         act;
    logic [W-1:0] alt0_q, alt1_q, alt2_q;
    logic [W-1:0] a_hold, b_hold, sum;

    always_comb begin
        ctrl_in.load1   = r1_ld;
        ctrl_in.load0   = r0_ld;
        ctrl_in.pick_hi = r1_pick_hi;
        ctrl_in.pick_lo = r1_pick_lo;
        ctrl_in.pick0   = r0_pick;
    end

    iso_activation #(.W(W)) u_act (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_in),
        .alt0_i(alt0), .alt1_i(alt1), .alt2_i(alt2),
        .act_o(act), .ctrl_q(ctrl_q),
        .alt0_q(alt0_q), .alt1_q(alt1_q), .alt2_q(alt2_q)
    );

    iso_hold #(.W(W), .CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .act_i(act),
        .a_i(opa), .b_i(opb), .a_q(a_hold), .b_q(b_hold),
        .tog_o(toggle_cnt)
    );

    always_comb sum = a_hold + b_hold;

    iso_dest #(.W(W)) u_dest (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .sum_i(sum),
        .alt0_q(alt0_q), .alt1_q(alt1_q), .alt2_q(alt2_q),
        .r0_o(r0_q), .r1_o(r1_q)
    );

    a_r2_r0_takes_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_ld && !r0_pick) |=> ##1 (r0_q == $past(a_hold + b_hold)));

    a_r8_both_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_ld && !r0_pick && r1_ld && !r1_pick_lo && !r1_pick_hi) |=> ##1 (r0_q == r1_q));

endmodule

// File: tb/iso_adder_dp_tb.sv
module iso_adder_dp_tb;

    localparam int W = 8;
    localparam int NV = 12;

    // entry layout: {r1_ld, r0_ld, r1_pick_hi, r1_pick_lo, r0_pick, A, B, alt0, alt1, alt2}
    localparam logic [44:0] VEC [NV] = '{
        {5'b01000, 8'h12, 8'h34, 8'hA0, 8'hB0, 8'hC0},
        {5'b10000, 8'hFF, 8'h02, 8'hA1, 8'hB1, 8'hC1},
        {5'b01001, 8'h55, 8'h55, 8'h3C, 8'hB2, 8'hC2},
        {5'b10010, 8'h00, 8'h00, 8'hA3, 8'h5A, 8'hC3},
        {5'b10110, 8'h77, 8'h11, 8'hA4, 8'h66, 8'h99},
        {5'b10100, 8'h01, 8'h01, 8'hA5, 8'hB5, 8'h7E},
        {5'b00000, 8'hEE, 8'hDD, 8'hA6, 8'hB6, 8'hC6},
        {5'b11000, 8'h80, 8'h80, 8'hA7, 8'hB7, 8'hC7},
        {5'b11111, 8'h0F, 8'hF0, 8'h11, 8'h22, 8'h33},
        {5'b00111, 8'hAB, 8'hCD, 8'h44, 8'h55, 8'h66},
        {5'b01000, 8'h39, 8'h07, 8'hA8, 8'hB8, 8'hC8},
        {5'b11010, 8'h10, 8'h20, 8'hA9, 8'h4D, 8'hC9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] opa = '0, opb = '0, alt0 = '0, alt1 = '0, alt2 = '0;
    logic r0_pick = 0, r1_pick_lo = 0, r1_pick_hi = 0, r0_ld = 0, r1_ld = 0;
    logic [W-1:0] r0_q, r1_q;
    logic [15:0] toggle_cnt;

    always #2 clk = ~clk;

    iso_adder_dp #(.W(W), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .r0_pick(r0_pick), .r1_pick_lo(r1_pick_lo), .r1_pick_hi(r1_pick_hi),
        .r0_ld(r0_ld), .r1_ld(r1_ld), .alt0(alt0), .alt1(alt1), .alt2(alt2),
        .r0_q(r0_q), .r1_q(r1_q), .toggle_cnt(toggle_cnt)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // reference model: a plain datapath without isolation
    logic [44:0] pend;
    logic [W-1:0] m_r0, m_r1, m_a, m_b;
    logic [15:0] m_cnt;

    function automatic bit is_active(input logic [4:0] c);
        return (c[3] && !c[0]) || (c[4] && !c[1] && !c[2]);
    endfunction

    function automatic int hd(input logic [W-1:0] x, input logic [W-1:0] y);
        int n = 0;
        for (int i = 0; i < W; i++) if (x[i] != y[i]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        pend = '0; m_r0 = '0; m_r1 = '0; m_a = '0; m_b = '0; m_cnt = '0;
    endtask

    task automatic apply(input logic [44:0] v);
        logic [W-1:0] s;
        @(negedge clk);
        {r1_ld, r0_ld, r1_pick_hi, r1_pick_lo, r0_pick, opa, opb, alt0, alt1, alt2} = v;
        @(posedge clk);
        #1;
        s = pend[39:32] + pend[31:24];
        if (pend[43]) m_r0 = pend[40] ? pend[23:16] : s;
        if (pend[44]) m_r1 = pend[42] ? pend[7:0] : (pend[41] ? pend[15:8] : s);
        pend = v;
        if (is_active(v[44:40])) begin
            m_cnt = m_cnt + 16'(hd(v[39:32], m_a) + hd(v[31:24], m_b));
            m_a = v[39:32]; m_b = v[31:24];
        end
    endtask

    task automatic compare(input string tag);
        check(r0_q == m_r0, {tag, " r0"}, r0_q, m_r0);
        check(r1_q == m_r1, {tag, " r1"}, r1_q, m_r1);
        check(toggle_cnt == m_cnt, {tag, " cnt"}, toggle_cnt, m_cnt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {r1_ld, r0_ld, r1_pick_hi, r1_pick_lo, r0_pick, opa, opb, alt0, alt1, alt2} = '0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        logic [15:0] c0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: reset values while reset is held
        check(r0_q == 0 && r1_q == 0, "R1 regs", {r0_q, r1_q}, 0);
        check(toggle_cnt == 0, "R1 cnt", toggle_cnt, 0);
        rst_n = 1;

        // table walk: R2 R3 R4 R5 R8 R9 against the unisolated model
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            compare("R2 R3 R4 R5 R8 R9 table");
        end
        apply('0);
        compare("R5 drain");
        apply('0);
        compare("R5 drain");

        // R7: Hamming increments from the reset operands
        do_reset();
        apply({5'b01000, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00});
        check(toggle_cnt == 4, "R7 first", toggle_cnt, 4);
        apply({5'b10000, 8'hF0, 8'h01, 8'h00, 8'h00, 8'h00});
        check(toggle_cnt == 13, "R7 second", toggle_cnt, 13);
        check(r0_q == 8'h0F, "R2 sum after edge pair", r0_q, 8'h0F);

        // R6: idle vectors with wild operands leave the counter frozen
        c0 = toggle_cnt;
        apply({5'b11111, 8'hAA, 8'h55, 8'h01, 8'h02, 8'h03});
        apply({5'b00000, 8'h55, 8'hAA, 8'h04, 8'h05, 8'h06});
        apply({5'b01001, 8'hFF, 8'hFF, 8'h07, 8'h08, 8'h09});
        check(toggle_cnt == c0, "R6 idle cnt", toggle_cnt, c0);
        compare("R6 idle model");

        // R9: first active vector after the gap uses its own operands
        apply({5'b10000, 8'h21, 8'h03, 8'h00, 8'h00, 8'h00});
        apply('0);
        check(r1_q == 8'h24, "R9 fresh sum", r1_q, 8'h24);
        compare("R9 model");

        // R8: both registers take one sum
        apply({5'b11000, 8'hC8, 8'h64, 8'h00, 8'h00, 8'h00});
        apply('0);
        check(r0_q == 8'h2C && r1_q == 8'h2C, "R8 both", {r0_q, r1_q}, 16'h2C2C);

        // R4: alt2 outranks alt1 when both picks are set
        apply({5'b10110, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hA5});
        apply('0);
        check(r1_q == 8'hA5, "R4 alt2 priority", r1_q, 8'hA5);

        // R3: alt0 path into r0
        apply({5'b01001, 8'h00, 8'h00, 8'h3E, 8'h00, 8'h00});
        apply('0);
        check(r0_q == 8'h3E, "R3 alt0", r0_q, 8'h3E);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule